// File: doc/BRIEF.md
# Accumulator Add Unit With Status Flags

This block is a 32-bit accumulator datapath that performs an unsigned add or an add-with-carry of a memory operand into its accumulator. The operand is supplied one word per cycle, with a valid qualifier. After each add the unit updates zero, negative, carry and overflow status flags. A small counter records every add that produces a carry out of the top bit.

An operation is launched with a one-cycle start pulse, which carries an opcode select and a repeat count. With a repeat count of N, the operation consumes N+1 operands, one per accepted word. The unit stalls whenever the valid input is low. It holds busy high while operands are still owed and raises done for one cycle once the last operand has been absorbed.

A low-word unsigned add followed by a high-word add-with-carry forms a 64-bit sum. The overflow flag is sticky: additions only ever set it. The asynchronous active-low reset is released synchronously through a two-stage synchronizer, so the unit leaves reset two clock edges after the reset pin is deasserted.

Top module: `acc_add_unit`

## Requirements
- R1: After reset the accumulator is 0, the zero flag is 1, the negative, carry and overflow flags are 0, the carry counter is 0, and busy and done are 0.
- R2: With op_i = 0 (plain add), each accepted operand sets the accumulator to (accumulator + operand) modulo 2^32.
- R3: With op_i = 1 (add with carry), each accepted operand sets the accumulator to (accumulator + operand + carry flag) modulo 2^32. The carry flag used is the value left by the previous pass.
- R4: After every pass, the zero flag equals (accumulator == 0) and the negative flag equals accumulator bit 31.
- R5: After every pass, the carry flag equals the carry out of bit 31 of that pass's addition.
- R6: The overflow flag is set when the accumulator and the operand share bit 31 and the result's bit 31 differs from it. Once set, it stays set until reset.
- R7: The 6-bit carry counter increments by one for each pass that produces a carry, including intermediate passes of a repeated operation. It wraps from 63 to 0.
- R8: cnt_clr_i clears the carry counter at the next edge and takes priority over an increment in the same cycle.
- R9: A start with repeat count N accepts exactly N+1 operands. Busy is high from the cycle after start until the last operand is accepted. Done is high for exactly one cycle, the cycle after the last accept, with busy then low.
- R10: While busy and opnd_vld_i is low, the accumulator, flags and counter hold their values.
- R11: A start pulse while busy is ignored. An operand presented while not busy is ignored and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launches an operation when idle |
| op_i | input | 1 | 0 = plain add, 1 = add with carry |
| rpt_i | input | RPT_W | Extra passes after the first |
| opnd_i | input | DATA_W | Operand word |
| opnd_vld_i | input | 1 | Operand word valid |
| cnt_clr_i | input | 1 | Synchronous clear of the carry counter |
| acc_o | output | DATA_W | Accumulator |
| z_o | output | 1 | Zero flag |
| n_o | output | 1 | Negative flag |
| c_o | output | 1 | Carry flag |
| v_o | output | 1 | Sticky overflow flag |
| carry_cnt_o | output | CNT_W | Carry counter |
| busy_o | output | 1 | Operands still owed |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: DATA_W = 32, CNT_W = 6 and RPT_W = 8. The 6-bit counter makes the wrap from 63 to 0 reachable in one long repeated run of all-ones operands. The bench keeps repeat counts small so that many operations, with random valid gaps, fit in the run. Directed sequences drive the signed-overflow boundary, a sum that is exactly zero with a carry, and a carry chained into add-with-carry. Further directed sequences apply a counter clear together with a carrying pass, a start raised mid-operation, and operands presented while idle.

// File: rtl/acc_add_pkg.sv
package acc_add_pkg;
  typedef enum logic {
    OP_ADD  = 1'b0,
    OP_ADDC = 1'b1
  } add_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/acc_add_alu.sv
module acc_add_alu #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              zero_o,
  output logic              neg_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide    = {1'b0, acc_i} + {1'b0, opnd_i} + {{DATA_W{1'b0}}, cin_i};
    sum_o   = wide[MSB:0];
    carry_o = wide[DATA_W];
    ovf_o   = (acc_i[MSB] == opnd_i[MSB]) && (wide[MSB] != acc_i[MSB]);
    zero_o  = (wide[MSB:0] == '0);
    neg_o   = wide[MSB];
  end
endmodule

// File: rtl/acc_add_seq.sv
module acc_add_seq
  import acc_add_pkg::*;
#(
  parameter int RPT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  add_op_e          op_i,
  input  logic [RPT_W-1:0] rpt_i,
  input  logic             opnd_vld_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             accept_o,
  output add_op_e          op_o
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [RPT_W-1:0] rem_q, rem_d;
  add_op_e          op_q, op_d;
  logic             rem_en;

  always_comb begin
    busy_d   = busy_q;
    done_d   = 1'b0;
    rem_d    = rem_q;
    op_d     = op_q;
    rem_en   = 1'b0;
    accept_o = busy_q & opnd_vld_i;
    if (!busy_q && start_i) begin
      busy_d = 1'b1;
      rem_d  = rpt_i;
      op_d   = op_i;
      rem_en = 1'b1;
    end else if (accept_o) begin
      if (rem_q == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        rem_d  = rem_q - 1'b1;
        rem_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      op_q   <= OP_ADD;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (rem_en) begin
        rem_q <= rem_d;
        op_q  <= op_d;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;
endmodule

// File: rtl/acc_add_ovc.sv
module acc_add_ovc #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/acc_add_unit.sv
module acc_add_unit
  import acc_add_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6,
  parameter int RPT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [RPT_W-1:0]  rpt_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              opnd_vld_i,
  input  logic              cnt_clr_i,
  output logic [DATA_W-1:0] acc_o,
  output logic              z_o,
  output logic              n_o,
  output logic              c_o,
  output logic              v_o,
  output logic [CNT_W-1:0]  carry_cnt_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              accept;
  add_op_e           op_act;
  logic [DATA_W-1:0] acc_q, acc_d;
  flags_t            flg_q, flg_d;
  logic [DATA_W-1:0] sum;
  logic              alu_carry, alu_ovf, alu_zero, alu_neg;
  logic              cin;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  acc_add_seq #(.RPT_W(RPT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_i),
    .op_i       (add_op_e'(op_i)),
    .rpt_i      (rpt_i),
    .opnd_vld_i (opnd_vld_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .accept_o   (accept),
    .op_o       (op_act)
  );

  assign cin = (op_act == OP_ADDC) & flg_q.c;

  acc_add_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_i   (acc_q),
    .opnd_i  (opnd_i),
    .cin_i   (cin),
    .sum_o   (sum),
    .carry_o (alu_carry),
    .ovf_o   (alu_ovf),
    .zero_o  (alu_zero),
    .neg_o   (alu_neg)
  );

  acc_add_ovc #(.CNT_W(CNT_W)) u_ovc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr_i (cnt_clr_i),
    .inc_i (accept & alu_carry),
    .cnt_o (carry_cnt_o)
  );

  always_comb begin
    acc_d   = sum;
    flg_d.z = alu_zero;
    flg_d.n = alu_neg;
    flg_d.c = alu_carry;
    flg_d.v = flg_q.v | alu_ovf;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      acc_q <= '0;
      flg_q <= '{z: 1'b1, n: 1'b0, c: 1'b0, v: 1'b0};
    end else if (accept) begin
      acc_q <= acc_d;
      flg_q <= flg_d;
    end
  end

  assign acc_o = acc_q;
  assign z_o   = flg_q.z;
  assign n_o   = flg_q.n;
  assign c_o   = flg_q.c;
  assign v_o   = flg_q.v;
endmodule

// File: rtl/acc_add_chk.sv
module acc_add_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              busy_o,
  input logic              done_o,
  input logic              opnd_vld_i,
  input logic              cnt_clr_i,
  input logic              alu_carry,
  input logic [DATA_W-1:0] acc_o,
  input logic              z_o,
  input logic              n_o,
  input logic              c_o,
  input logic              v_o,
  input logic [CNT_W-1:0]  carry_cnt_o
);
  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    z_o == (acc_o == '0));
  assert_neg_flag_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    n_o == acc_o[DATA_W-1]);
  assert_v_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    v_o |=> v_o);
  assert_cnt_inc_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cnt_clr_i && busy_o && opnd_vld_i && alu_carry) |=>
      carry_cnt_o == CNT_W'($past(carry_cnt_o) + 1'b1));
  assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cnt_clr_i && !(busy_o && opnd_vld_i && alu_carry)) |=> $stable(carry_cnt_o));
  assert_cnt_clr_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    cnt_clr_i |=> carry_cnt_o == '0);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o);
  assert_busy_fall_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(busy_o) |-> done_o);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(busy_o && opnd_vld_i) |=> ($stable(acc_o) && $stable(c_o) && $stable(v_o)));
endmodule

bind acc_add_unit acc_add_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .opnd_vld_i  (opnd_vld_i),
  .cnt_clr_i   (cnt_clr_i),
  .alu_carry   (alu_carry),
  .acc_o       (acc_o),
  .z_o         (z_o),
  .n_o         (n_o),
  .c_o         (c_o),
  .v_o         (v_o),
  .carry_cnt_o (carry_cnt_o)
);

// File: tb/tb_acc_add_unit.sv
module tb_acc_add_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 6;
  localparam int RPT_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i;
  logic              op_i;
  logic [RPT_W-1:0]  rpt_i;
  logic [DATA_W-1:0] opnd_i;
  logic              opnd_vld_i;
  logic              cnt_clr_i;
  logic [DATA_W-1:0] acc_o;
  logic              z_o, n_o, c_o, v_o;
  logic [CNT_W-1:0]  carry_cnt_o;
  logic              busy_o, done_o;

  int tests = 0;
  int fails = 0;

  logic [DATA_W-1:0] m_acc;
  logic              m_z, m_n, m_c, m_v;
  logic [CNT_W-1:0]  m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_add_unit #(.DATA_W(DATA_W), .CNT_W(CNT_W), .RPT_W(RPT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rpt_i(rpt_i),
    .opnd_i(opnd_i), .opnd_vld_i(opnd_vld_i), .cnt_clr_i(cnt_clr_i),
    .acc_o(acc_o), .z_o(z_o), .n_o(n_o), .c_o(c_o), .v_o(v_o),
    .carry_cnt_o(carry_cnt_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " acc"}, 64'(acc_o), 64'(m_acc));
    chk({tag, " z"}, 64'(z_o), 64'(m_z));
    chk({tag, " n"}, 64'(n_o), 64'(m_n));
    chk({tag, " c"}, 64'(c_o), 64'(m_c));
    chk({tag, " v"}, 64'(v_o), 64'(m_v));
    chk({tag, " cnt"}, 64'(carry_cnt_o), 64'(m_cnt));
  endtask

  // model of one pass: R2/R3 sum, R4 flags, R5 carry, R6 sticky V, R7/R8 counter
  task automatic model_pass(input logic op, input logic [DATA_W-1:0] d, input logic clr);
    logic [DATA_W:0] w;
    logic            cin;
    cin = op & m_c;
    w = {1'b0, m_acc} + {1'b0, d} + {{DATA_W{1'b0}}, cin};
    if ((m_acc[DATA_W-1] == d[DATA_W-1]) && (w[DATA_W-1] != m_acc[DATA_W-1])) m_v = 1'b1;
    m_acc = w[DATA_W-1:0];
    m_c   = w[DATA_W];
    m_z   = (m_acc == '0);
    m_n   = m_acc[DATA_W-1];
    if (clr)      m_cnt = '0;
    else if (m_c) m_cnt = m_cnt + 1'b1;
  endtask

  // one full operation; ops may contain fixed values or random ones
  task automatic run_op(input logic op, input int rpt, input logic [DATA_W-1:0] fixed,
                        input bit use_fixed, input int max_gap, input bit poke_start);
    logic [DATA_W-1:0] d;
    logic              clr;
    start_i = 1'b1; op_i = op; rpt_i = RPT_W'(rpt);
    @(negedge clk);
    start_i = 1'b0;
    chk("R9 busy after start", 64'(busy_o), 64'd1);
    for (int p = 0; p <= rpt; p++) begin
      int gap;
      gap = (max_gap == 0) ? 0 : int'($urandom_range(max_gap, 0));
      for (int g = 0; g < gap; g++) begin
        opnd_i = $urandom();
        @(negedge clk);
        chk_state("R10 stall");
      end
      d = use_fixed ? fixed : $urandom();
      clr = (!use_fixed) && ($urandom_range(9, 0) == 0);
      opnd_i = d; opnd_vld_i = 1'b1; cnt_clr_i = clr;
      if (poke_start && p == 0) begin
        start_i = 1'b1; op_i = ~op; rpt_i = '0;
      end
      @(negedge clk);
      opnd_vld_i = 1'b0; cnt_clr_i = 1'b0; start_i = 1'b0;
      model_pass(op, d, clr);
      chk_state(op ? "R3 addc pass" : "R2 add pass");
      if (clr) chk("R8 clr priority", 64'(carry_cnt_o), 64'(m_cnt));
      if (p == rpt) begin
        chk("R9 busy low at end", 64'(busy_o), 64'd0);
        chk("R9 done pulse", 64'(done_o), 64'd1);
      end else begin
        chk("R9 busy mid / R11 start ignored", 64'(busy_o), 64'd1);
        chk("R9 no early done", 64'(done_o), 64'd0);
      end
    end
    @(negedge clk);
    chk("R9 done one cycle", 64'(done_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; op_i = 1'b0; rpt_i = '0;
    opnd_i = '0; opnd_vld_i = 1'b0; cnt_clr_i = 1'b0;
    m_acc = '0; m_z = 1'b1; m_n = 1'b0; m_c = 1'b0; m_v = 1'b0; m_cnt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_state("R1 reset");
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);

    // R11: operand while idle is ignored
    opnd_i = 32'h1234_5678; opnd_vld_i = 1'b1;
    @(negedge clk);
    opnd_vld_i = 1'b0;
    chk_state("R11 idle operand");

    // directed: signed overflow boundary, zero with carry, carry into ADDC
    run_op(1'b0, 0, 32'h7FFF_FFFF, 1'b1, 0, 1'b0);
    run_op(1'b0, 0, 32'h0000_0001, 1'b1, 0, 1'b0);
    chk("R6 overflow set", 64'(v_o), 64'd1);
    run_op(1'b0, 0, 32'h8000_0000, 1'b1, 0, 1'b0);
    chk("R5 carry at zero", 64'(c_o), 64'd1);
    chk("R4 zero", 64'(z_o), 64'd1);
    run_op(1'b1, 0, 32'h0000_0005, 1'b1, 0, 1'b0);
    chk("R3 carry in", 64'(acc_o), 64'd6);
    chk("R6 sticky", 64'(v_o), 64'd1);

    // R8: idle clear
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0; m_cnt = '0;
    chk("R8 clear", 64'(carry_cnt_o), 64'd0);

    // R7: wrap through 64 carries with all-ones operands
    run_op(1'b0, 70, 32'hFFFF_FFFF, 1'b1, 0, 1'b0);
    chk("R7 wrap", 64'(carry_cnt_o), 64'(m_cnt));

    // R11: start while busy
    run_op(1'b0, 3, '0, 1'b0, 2, 1'b1);

    // random mix
    for (int k = 0; k < 300; k++)
      run_op(1'(int'($urandom_range(1, 0))), int'($urandom_range(5, 0)), '0, 1'b0, 3, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule